// File: doc/BRIEF.md
# Two-Queue Interrupt Level and Vector Unit

This block is the interrupt front end of a converter peripheral that runs two conversion queues. Each queue raises two kinds of events, a completion and a pause, so there are four internal sources in all. Every queue has its own programmable request level, from 1 to 7, where 0 switches that queue off. A pending source drives the request line that matches its queue's level.

When the CPU acknowledges an interrupt, it presents the level it is serving together with the highest arbitration ID offered by the other modules at that level. The block claims the cycle only under three conditions: the level matches one of its pending sources, its own arbitration ID is non-zero, and its ID beats every rival. When it claims, it returns an 8-bit vector. The upper six bits come from a programmable base and the lower two bits name the source being served. The pending flag of that source is then cleared.

The registers sit on a simple word bus that carries a supervisor qualifier. User-mode accesses to protected locations are refused. A configuration bit widens the protected set from the three control registers to the whole map.

Top module: `qirq_front`

## Requirements
- R1: After reset, both queue levels are 0, the arbitration ID is 0 and the supervisor bit is 1. A read of the interrupt register returns 0x000F, a read of the configuration register returns 0x0080, and all request lines are low.
- R2: The interrupt register is at address 2. Bits 14:12 hold the queue 1 level, bits 10:8 hold the queue 2 level and bits 7:2 hold the vector base. Bits 15 and 11 always read 0. Bits 1:0 read 11 until the register is first written and read 00 from then on.
- R3: The configuration register is at address 0. Bit 7 is the supervisor bit and bits 3:0 are the arbitration ID. All other bits read 0. The test register at address 1 reads 0 and ignores writes.
- R4: A pulse on srcReq bit i sets pending flag i. Bit 0 is the queue 1 completion, bit 1 the queue 1 pause, bit 2 the queue 2 completion and bit 3 the queue 2 pause. Request line irqReq[L-1] is high while any pending source belongs to a queue whose level is L, with L in 1 to 7. The state is visible on the lines in the cycle after the pulse.
- R5: A queue at level 0 drives no request line, even if its sources are pending, and it is never claimed in an acknowledge.
- R6: An acknowledge with iackLevel equal to the level of a pending source is claimed. The claim also needs a winning, non-zero arbitration ID. ackClaim and ackVector are valid in the cycle after iackValid. Without a claim, ackClaim is 0 and ackVector is 0.
- R7: The claimed vector is the base (bits 7:2) joined to the 2-bit code of the served source in bits 1:0.
- R8: Among the pending sources at the acknowledged level, the lowest code is served first. The served source's pending flag is cleared. A new event on that source in the same cycle leaves it pending.
- R9: An arbitration ID of 0 never claims. The block also does not claim, and clears nothing, when rivalId is greater than or equal to its own ID.
- R10: The configuration, test and interrupt registers are always supervisor-only. A user-mode access to one of them writes nothing and reads 0. It raises accErr for one cycle, in the cycle after the access.
- R11: With the supervisor bit at 1, every address, table included, is supervisor-only. With it at 0, the table is open to user-mode reads and writes without error. Supervisor accesses never raise accErr.
- R12: The table holds TAB_DEPTH words at addresses TAB_BASE onward. A write stores all 16 bits. Read data appears on accRdata in the cycle after the read, and accRdata is 0 in the cycle after any non-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Register access strobe |
| accWrite | input | 1 | 1 for write, 0 for read |
| accSuper | input | 1 | Access made in supervisor mode |
| accAddr | input | ADDR_W | Word address |
| accWdata | input | 16 | Write data |
| accRdata | output | 16 | Read data, one cycle after the read |
| accErr | output | 1 | Refused access, one-cycle pulse |
| srcReq | input | 4 | Source event pulses, codes 0 to 3 |
| irqReq | output | 7 | Request lines, bit L-1 for level L |
| iackValid | input | 1 | Acknowledge cycle strobe |
| iackLevel | input | 3 | Level being acknowledged |
| rivalId | input | 4 | Highest competing arbitration ID |
| ackClaim | output | 1 | Block claims the acknowledge |
| ackVector | output | 8 | Returned vector |

## Verification
Read data, accErr, ackClaim and ackVector all come from registers, so each is due exactly one cycle after the stimulus that produces it. The request lines follow the pending flags through logic alone and reflect a source pulse one cycle after it. The bench drives at falling edges and tags each expected item with the cycle in which it is due. The monitor compares only at the falling edge of that cycle, so no item is sampled early or late.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_SRC = 4;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int ID_W    = 4;
  localparam int CODE_W  = $clog2(NUM_SRC);

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_INT  = 2'd2,
    RD_TAB  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              cfgWe;
    logic              intWe;
    logic              tabWe;
    rdSel_e            rdSel;
    logic              accErr;
    logic              ackClaim;
    logic [CODE_W-1:0] ackCode;
  } strobe_t;
endpackage

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
  import qirq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int TAB_BASE  = 8,
  parameter int TAB_DEPTH = 8
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSuper,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              iackValid,
  input  logic [LVL_W-1:0]  iackLevel,
  input  logic [ID_W-1:0]   rivalId,
  input  logic              supOnly,
  input  logic [ID_W-1:0]   arbId,
  input  logic [LVL_W-1:0]  lvlQ1,
  input  logic [LVL_W-1:0]  lvlQ2,
  input  logic [NUM_SRC-1:0] pending,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_TST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_INT = ADDR_W'(2);
  localparam logic [ADDR_W:0]   TAB_LO   = (ADDR_W+1)'(TAB_BASE);
  localparam logic [ADDR_W:0]   TAB_HI   = (ADDR_W+1)'(TAB_BASE + TAB_DEPTH);

  logic isCfg, isTst, isInt, isTab, protLoc, denied, granted;

  assign isCfg   = (accAddr == ADDR_CFG);
  assign isTst   = (accAddr == ADDR_TST);
  assign isInt   = (accAddr == ADDR_INT);
  assign isTab   = ({1'b0, accAddr} >= TAB_LO) && ({1'b0, accAddr} < TAB_HI);
  // control registers are always guarded; the supervisor bit guards the rest
  assign protLoc = isCfg || isTst || isInt || supOnly;
  assign denied  = accValid && !accSuper && protLoc;
  assign granted = accValid && !denied;

  // acknowledge matching per source
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_SRC / 2) begin : g_q1
      assign srcLvl[s] = lvlQ1;
    end else begin : g_q2
      assign srcLvl[s] = lvlQ2;
    end
    assign hit[s] = pending[s] && (srcLvl[s] != '0) && (srcLvl[s] == iackLevel);
  end

  logic [CODE_W-1:0] hitCode;
  logic              anyHit;
  logic              idWins;

  always_comb begin
    hitCode = '0;
    anyHit  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hitCode = CODE_W'(i);
        anyHit  = 1'b1;
      end
    end
  end

  assign idWins = (arbId != '0) && (arbId > rivalId);

  always_comb begin
    stb          = '0;
    stb.cfgWe    = granted && accWrite && isCfg;
    stb.intWe    = granted && accWrite && isInt;
    stb.tabWe    = granted && accWrite && isTab;
    stb.accErr   = denied;
    stb.rdSel    = RD_NONE;
    if (granted && !accWrite) begin
      if (isCfg)      stb.rdSel = RD_CFG;
      else if (isInt) stb.rdSel = RD_INT;
      else if (isTab) stb.rdSel = RD_TAB;
    end
    stb.ackClaim = iackValid && anyHit && idWins;
    stb.ackCode  = hitCode;
  end
endmodule

// File: rtl/qirq_dpath.sv
module qirq_dpath
  import qirq_pkg::*;
#(
  parameter int TAB_DEPTH = 8,
  localparam int TAB_IW   = $clog2(TAB_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [TAB_IW-1:0]  tabIdx,
  input  logic [DATA_W-1:0]  accWdata,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic               supOnly,
  output logic [ID_W-1:0]    arbId,
  output logic [LVL_W-1:0]   lvlQ1,
  output logic [LVL_W-1:0]   lvlQ2,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_LVL-1:0] irqLines,
  output logic [DATA_W-1:0]  rdData,
  output logic               accErr,
  output logic               ackClaim,
  output logic [7:0]         ackVector
);
  logic                supQ;
  logic [ID_W-1:0]     arbIdQ;
  logic [LVL_W-1:0]    lvlQ1Q, lvlQ2Q;
  logic [5:0]          baseQ;
  logic                baseWrQ;
  logic [NUM_SRC-1:0]  pendQ;
  logic [DATA_W-1:0]   tabMem [TAB_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supQ   <= 1'b1;
      arbIdQ <= '0;
    end else if (stb.cfgWe) begin
      supQ   <= accWdata[7];
      arbIdQ <= accWdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ1Q  <= '0;
      lvlQ2Q  <= '0;
      baseQ   <= 6'b000011;
      baseWrQ <= 1'b0;
    end else if (stb.intWe) begin
      lvlQ1Q  <= accWdata[14:12];
      lvlQ2Q  <= accWdata[10:8];
      baseQ   <= accWdata[7:2];
      baseWrQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.tabWe) tabMem[tabIdx] <= accWdata;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)                                          pendQ[i] <= 1'b0;
      else if (srcReq[i])                                 pendQ[i] <= 1'b1;
      else if (stb.ackClaim && stb.ackCode == CODE_W'(i)) pendQ[i] <= 1'b0;
    end
  end

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    assign irqLines[l-1] = ((|pendQ[1:0]) && (lvlQ1Q == LVL_W'(l))) ||
                           ((|pendQ[3:2]) && (lvlQ2Q == LVL_W'(l)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      accErr    <= 1'b0;
      ackClaim  <= 1'b0;
      ackVector <= '0;
    end else begin
      unique case (stb.rdSel)
        RD_CFG:  rdData <= {8'h00, supQ, 3'b000, arbIdQ};
        RD_INT:  rdData <= {1'b0, lvlQ1Q, 1'b0, lvlQ2Q, baseQ, baseWrQ ? 2'b00 : 2'b11};
        RD_TAB:  rdData <= tabMem[tabIdx];
        default: rdData <= '0;
      endcase
      accErr    <= stb.accErr;
      ackClaim  <= stb.ackClaim;
      ackVector <= stb.ackClaim ? {baseQ, stb.ackCode} : 8'h00;
    end
  end

  assign supOnly = supQ;
  assign arbId   = arbIdQ;
  assign lvlQ1   = lvlQ1Q;
  assign lvlQ2   = lvlQ2Q;
  assign pending = pendQ;

  assert_served_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackClaim && !srcReq[stb.ackCode]) |=> !pendQ[$past(stb.ackCode)]);

  assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackClaim |-> (ackVector[7:2] == $past(baseQ)));

  assert_no_claim_id0_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackClaim |-> ($past(arbIdQ) != '0));

  assert_denied_nochange_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.accErr |=> ($stable(lvlQ1Q) && $stable(lvlQ2Q) && $stable(baseQ) &&
                    $stable(supQ) && $stable(arbIdQ)));
endmodule

// File: rtl/qirq_front.sv
module qirq_front
  import qirq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int TAB_BASE  = 8,
  parameter int TAB_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSuper,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [15:0]       accWdata,
  output logic [15:0]       accRdata,
  output logic              accErr,
  input  logic [3:0]        srcReq,
  output logic [6:0]        irqReq,
  input  logic              iackValid,
  input  logic [2:0]        iackLevel,
  input  logic [3:0]        rivalId,
  output logic              ackClaim,
  output logic [7:0]        ackVector
);
  localparam int TAB_IW = $clog2(TAB_DEPTH);

  strobe_t            stb;
  logic               supOnly;
  logic [ID_W-1:0]    arbId;
  logic [LVL_W-1:0]   lvlQ1, lvlQ2;
  logic [NUM_SRC-1:0] pending;

  qirq_ctrl #(.ADDR_W(ADDR_W), .TAB_BASE(TAB_BASE), .TAB_DEPTH(TAB_DEPTH)) u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accSuper (accSuper),
    .accAddr  (accAddr),
    .iackValid(iackValid),
    .iackLevel(iackLevel),
    .rivalId  (rivalId),
    .supOnly  (supOnly),
    .arbId    (arbId),
    .lvlQ1    (lvlQ1),
    .lvlQ2    (lvlQ2),
    .pending  (pending),
    .stb      (stb)
  );

  qirq_dpath #(.TAB_DEPTH(TAB_DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tabIdx   (accAddr[TAB_IW-1:0]),
    .accWdata (accWdata),
    .srcReq   (srcReq),
    .supOnly  (supOnly),
    .arbId    (arbId),
    .lvlQ1    (lvlQ1),
    .lvlQ2    (lvlQ2),
    .pending  (pending),
    .irqLines (irqReq),
    .rdData   (accRdata),
    .accErr   (accErr),
    .ackClaim (ackClaim),
    .ackVector(ackVector)
  );

  assert_err_from_user_R10: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(accValid && !accSuper));

  assert_err_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (accRdata == 16'h0000));

  assert_lvl0_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (iackValid && iackLevel == 3'd0) |=> !ackClaim);

  assert_two_lines_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqReq) <= 2);
endmodule

// File: tb/qirq_front_bench.sv
module qirq_front_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accSuper = 1'b0;
  logic [3:0]  accAddr = '0;
  logic [15:0] accWdata = '0;
  logic [15:0] accRdata;
  logic        accErr;
  logic [3:0]  srcReq = '0;
  logic [6:0]  irqReq;
  logic        iackValid = 1'b0;
  logic [2:0]  iackLevel = '0;
  logic [3:0]  rivalId = '0;
  logic        ackClaim;
  logic [7:0]  ackVector;

  always #2.5 clk = ~clk;

  qirq_front u_qirq_front (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSuper(accSuper), .accAddr(accAddr), .accWdata(accWdata),
    .accRdata(accRdata), .accErr(accErr), .srcReq(srcReq), .irqReq(irqReq),
    .iackValid(iackValid), .iackLevel(iackLevel), .rivalId(rivalId),
    .ackClaim(ackClaim), .ackVector(ackVector)
  );

  typedef struct {
    int          kind;   // 0 access, 1 acknowledge, 2 request lines
    logic [15:0] a;
    logic [15:0] b;
    int          due;
    string       tag;
  } item_t;

  item_t queueExp[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (queueExp.size() > 0 && queueExp[0].due == cyc) begin
      item_t it;
      it = queueExp.pop_front();
      total++;
      case (it.kind)
        0: if (accRdata !== it.a || accErr !== it.b[0]) begin
             bad++;
             $display("FAIL %s access: rdata=%h err=%b expected rdata=%h err=%b",
                      it.tag, accRdata, accErr, it.a, it.b[0]);
           end
        1: if (ackClaim !== it.b[0] || ackVector !== it.a[7:0]) begin
             bad++;
             $display("FAIL %s ack: claim=%b vec=%h expected claim=%b vec=%h",
                      it.tag, ackClaim, ackVector, it.b[0], it.a[7:0]);
           end
        default: if (irqReq !== it.a[6:0]) begin
             bad++;
             $display("FAIL %s lines: irq=%b expected irq=%b", it.tag, irqReq, it.a[6:0]);
           end
      endcase
    end
  end

  task automatic idleIn();
    accValid = 1'b0; accWrite = 1'b0; accSuper = 1'b0; accAddr = '0; accWdata = '0;
    srcReq = '0; iackValid = 1'b0; iackLevel = '0; rivalId = '0;
  endtask

  task automatic push(int kind, logic [15:0] a, logic [15:0] b, string tag);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.due = cyc + 1; it.tag = tag;
    queueExp.push_back(it);
  endtask

  task automatic access(bit wr, bit sup, logic [3:0] addr, logic [15:0] wd,
                        logic [15:0] expRd, bit expErr, string tag);
    @(negedge clk);
    idleIn();
    accValid = 1'b1; accWrite = wr; accSuper = sup; accAddr = addr; accWdata = wd;
    push(0, expRd, {15'b0, expErr}, tag);
  endtask

  task automatic srcPulse(logic [3:0] mask);
    @(negedge clk);
    idleIn();
    srcReq = mask;
  endtask

  task automatic ack(logic [2:0] lvl, logic [3:0] rival, logic [3:0] mask,
                     bit expClaim, logic [7:0] expVec, string tag);
    @(negedge clk);
    idleIn();
    iackValid = 1'b1; iackLevel = lvl; rivalId = rival; srcReq = mask;
    push(1, {8'h00, expVec}, {15'b0, expClaim}, tag);
  endtask

  task automatic lines(logic [6:0] exp, string tag);
    @(negedge clk);
    idleIn();
    push(2, {9'b0, exp}, 16'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    lines(7'b0, "R1");
    access(0, 1, 4'd0, 16'h0, 16'h0080, 0, "R1");
    access(0, 1, 4'd2, 16'h0, 16'h000F, 0, "R1");
    // R2 layout, reserved bits dropped, low base bits read zero once written
    access(1, 1, 4'd2, 16'hBD43, 16'h0, 0, "R2");
    access(0, 1, 4'd2, 16'h0, 16'h3540, 0, "R2");
    // R3 config layout and test register
    access(1, 1, 4'd0, 16'hFFF5, 16'h0, 0, "R3");
    access(0, 1, 4'd0, 16'h0, 16'h0085, 0, "R3");
    access(1, 1, 4'd1, 16'hFFFF, 16'h0, 0, "R3");
    access(0, 1, 4'd1, 16'h0, 16'h0000, 0, "R3");
    // R10 user access to control registers refused
    access(0, 0, 4'd0, 16'h0, 16'h0000, 1, "R10");
    access(1, 0, 4'd2, 16'h0000, 16'h0000, 1, "R10");
    access(0, 1, 4'd2, 16'h0, 16'h3540, 0, "R10");
    // R11/R12 table under full protection, then opened
    access(1, 1, 4'd8, 16'hAAAA, 16'h0, 0, "R12");
    access(1, 0, 4'd8, 16'h1234, 16'h0, 1, "R11");
    access(0, 1, 4'd8, 16'h0, 16'hAAAA, 0, "R11");
    access(1, 1, 4'd0, 16'h0005, 16'h0, 0, "R11");
    access(1, 0, 4'd9, 16'h5A5A, 16'h0, 0, "R11");
    access(0, 0, 4'd9, 16'h0, 16'h5A5A, 0, "R12");
    access(0, 0, 4'd0, 16'h0, 16'h0000, 1, "R10");
    access(1, 1, 4'd0, 16'h0085, 16'h0, 0, "R3");
    // R4 request lines: queue 1 at level 3, queue 2 at level 5
    srcPulse(4'b0001);
    lines(7'b0000100, "R4");
    srcPulse(4'b1000);
    lines(7'b0010100, "R4");
    // R6/R7 acknowledge of level 5 serves queue 2 pause
    ack(3'd5, 4'd0, 4'b0, 1, 8'h43, "R7");
    lines(7'b0000100, "R8");
    // R8 fixed order at one level
    srcPulse(4'b0010);
    ack(3'd3, 4'd0, 4'b0, 1, 8'h40, "R8");
    ack(3'd3, 4'd0, 4'b0, 1, 8'h41, "R8");
    ack(3'd3, 4'd0, 4'b0, 0, 8'h00, "R6");
    lines(7'b0, "R8");
    // R9 rival arbitration
    srcPulse(4'b0010);
    ack(3'd3, 4'd7, 4'b0, 0, 8'h00, "R9");
    ack(3'd3, 4'd5, 4'b0, 0, 8'h00, "R9");
    lines(7'b0000100, "R9");
    ack(3'd3, 4'd4, 4'b0, 1, 8'h41, "R9");
    // R9 arbitration ID zero never claims
    access(1, 1, 4'd0, 16'h0080, 16'h0, 0, "R9");
    srcPulse(4'b0100);
    ack(3'd5, 4'd0, 4'b0, 0, 8'h00, "R9");
    lines(7'b0010000, "R9");
    access(1, 1, 4'd0, 16'h0085, 16'h0, 0, "R9");
    ack(3'd5, 4'd0, 4'b0, 1, 8'h42, "R6");
    // R5 level zero silences queue 1
    access(1, 1, 4'd2, 16'h0540, 16'h0, 0, "R5");
    srcPulse(4'b0001);
    lines(7'b0, "R5");
    ack(3'd0, 4'd0, 4'b0, 0, 8'h00, "R5");
    access(1, 1, 4'd2, 16'h2540, 16'h0, 0, "R5");
    lines(7'b0000010, "R5");
    ack(3'd2, 4'd0, 4'b0, 1, 8'h40, "R6");
    // R8 new event in the same cycle as its acknowledge stays pending
    srcPulse(4'b0100);
    ack(3'd5, 4'd0, 4'b0100, 1, 8'h42, "R8");
    lines(7'b0010000, "R8");
    ack(3'd5, 4'd0, 4'b0, 1, 8'h42, "R8");
    lines(7'b0, "R8");
    @(negedge clk);
    idleIn();
    repeat (3) @(negedge clk);
    if (queueExp.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", queueExp.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule